// File: doc/BRIEF.md
# Pack/Unpack Element Index Sequencer

This block drives a vector register move by producing, one per cycle, a pair of element offsets: the element to read and the element to write. A start pulse latches a group count, a destination sub-vector length and, in split mode, a separate source sub-vector length. The pairs then leave on a valid/ready handshake. Two counter state machines, one per side, move forward together on every accepted pair, so the n-th read offset always goes with the n-th write offset.

In shared mode both sides use the destination length and walk memory linearly. In split mode each side visits its elements with the sub-element index as the outer loop and the group index as the inner loop. Giving the two sides different lengths therefore interleaves (packs) or de-interleaves (unpacks) groups. The sequence cannot be split up. An interrupt request is acknowledged only when no sequence is in flight. A separate cancel input abandons the sequence at once.

Top module: `pkidx_seq`

## Requirements
- R1: In shared mode (`split_mode`=0) the pair count T is `vec_len`*`dst_sub`, and pair n carries `src_off` = `dst_off` = n for n = 0..T-1. `src_sub` is ignored in this mode, even when its value is out of range.
- R2: In split mode (`split_mode`=1), M is the larger of the two lengths and T = `vec_len`*M. A side with length s has T/s rows. Its n-th offset is (n mod rows)*s + n div rows, so the sub-element index is the outer loop and the row is the inner loop. A length of 1 therefore gives a linear walk. Both lengths may exceed 1.
- R3: The design emits exactly T pairs, one per cycle in which `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, both offsets stay unchanged into the next cycle.
- R4: A start pulse is taken only when the block is idle, meaning `busy` and `done` are both low. It latches all parameters. `busy` and `out_valid` are high from the cycle after the start until the last pair is accepted. A start seen while busy has no effect on the sequence.
- R5: `done` is high for exactly one cycle, the cycle after the last pair is accepted, and `busy` is low in that cycle.
- R6: A start with `vec_len`=0 emits no pair. `done` is raised in the next cycle, with `len_err` low.
- R7: A start with an invalid request emits no pair. `done` and `len_err` are raised together in the next cycle. A request is invalid if any of these holds: a used length lies outside 1..4, `vec_len` exceeds 64, or T is not a multiple of a used side's length.
- R8: `irq_ack` follows `irq_req` in every cycle where `busy` is low, and is held low while `busy` is high.
- R9: `cancel` while busy returns the block to idle in the next cycle. No further pair is emitted and `done` is not raised.
- R10: After reset, `out_valid`, `busy`, `done` and `len_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch the parameters and begin a sequence |
| vec_len | input | 7 | Group count, 0 to 64 |
| split_mode | input | 1 | 1: separate source length, outer sub-element loop |
| src_sub | input | 3 | Source sub-vector length (split mode only) |
| dst_sub | input | 3 | Destination sub-vector length |
| cancel | input | 1 | Abandon the sequence immediately |
| irq_req | input | 1 | Interrupt request level |
| out_ready | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | Offset pair is valid |
| src_off | output | 8 | Source element offset |
| dst_off | output | 8 | Destination element offset |
| busy | output | 1 | Sequence in flight |
| done | output | 1 | One-cycle completion pulse |
| len_err | output | 1 | Request rejected, high alongside `done` |
| irq_ack | output | 1 | Interrupt acknowledged |

## Verification
The collision that matters is between interrupt gating and completion of the final pair. The bench holds `irq_req` high for the whole of an unpack sequence with a stalling consumer, so the request is pending when the last pair is accepted. `irq_ack` must stay low in every busy cycle, including the one where the last handshake happens. It must first appear in the cycle where `done` is high. A second collision, `cancel` arriving together with an accepted pair, is judged by requiring that the block is idle and `done` stays low afterwards.

// File: rtl/pkidx_pkg.sv
package pkidx_pkg;
    parameter int VL_W    = 7;
    parameter int SUB_W   = 3;
    parameter int OFF_W   = 8;
    parameter int CNT_W   = OFF_W + 1;
    parameter int MAX_VL  = 64;
    parameter int MAX_SUB = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pkidx_plan.sv
module pkidx_plan
    import pkidx_pkg::*;
#(
    parameter int P_VL_W    = VL_W,
    parameter int P_SUB_W   = SUB_W,
    parameter int P_CNT_W   = CNT_W,
    parameter int P_MAX_VL  = MAX_VL,
    parameter int P_MAX_SUB = MAX_SUB
) (
    input  logic [P_VL_W-1:0]  vl,
    input  logic [P_SUB_W-1:0] s_sub,
    input  logic [P_SUB_W-1:0] d_sub,
    input  logic               split,
    output logic [P_SUB_W-1:0] src_eff,
    output logic [P_CNT_W-1:0] total,
    output logic               bad
);
    localparam logic [P_VL_W-1:0]  VL_LIM  = P_VL_W'(P_MAX_VL);
    localparam logic [P_SUB_W-1:0] SUB_LIM = P_SUB_W'(P_MAX_SUB);

    function automatic logic rem_nz(input logic [P_CNT_W-1:0] t,
                                    input logic [P_SUB_W-1:0] s);
        case (s)
            P_SUB_W'(2): return t[0];
            P_SUB_W'(3): return (t % P_CNT_W'(3)) != '0;
            P_SUB_W'(4): return t[1:0] != 2'b00;
            default:     return 1'b0;
        endcase
    endfunction

    logic [P_SUB_W-1:0] mx;
    logic [P_CNT_W-1:0] vx;
    logic               range_bad;

    always_comb begin
        src_eff = split ? s_sub : d_sub;
        mx      = (src_eff > d_sub) ? src_eff : d_sub;
        vx      = P_CNT_W'(vl);
        case (mx)
            P_SUB_W'(1): total = vx;
            P_SUB_W'(2): total = vx << 1;
            P_SUB_W'(3): total = (vx << 1) + vx;
            P_SUB_W'(4): total = vx << 2;
            default:     total = '0;
        endcase
        range_bad = (d_sub == '0) || (d_sub > SUB_LIM) ||
                    (src_eff == '0) || (src_eff > SUB_LIM) || (vl > VL_LIM);
        bad = range_bad || rem_nz(total, src_eff) || rem_nz(total, d_sub);
    end
endmodule

// File: rtl/pkidx_walker.sv
module pkidx_walker
    import pkidx_pkg::*;
#(
    parameter int P_OFF_W = OFF_W,
    parameter int P_SUB_W = SUB_W,
    parameter int P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               strided,
    input  logic [P_SUB_W-1:0] sub,
    input  logic [P_CNT_W-1:0] total,
    output logic [P_OFF_W-1:0] off
);
    typedef struct packed {
        logic [P_OFF_W-1:0] off;
        logic [P_SUB_W-1:0] j;
    } wk_t;

    wk_t                q, d;
    logic [P_CNT_W-1:0] sum;

    always_comb begin
        d   = q;
        sum = P_CNT_W'(q.off) + P_CNT_W'(sub);
        if (load) begin
            d.off = '0;
            d.j   = '0;
        end else if (step) begin
            if (!strided) begin
                d.off = q.off + P_OFF_W'(1);
            end else if (sum >= total) begin
                d.off = P_OFF_W'(q.j) + P_OFF_W'(1);
                d.j   = q.j + P_SUB_W'(1);
            end else begin
                d.off = sum[P_OFF_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign off = q.off;

    // R2
    off_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (P_CNT_W'(q.off) < total));

    // R2
    outer_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && strided) |-> (q.j < sub));
endmodule

// File: rtl/pkidx_seq.sv
module pkidx_seq
    import pkidx_pkg::*;
#(
    parameter int P_VL_W    = VL_W,
    parameter int P_SUB_W   = SUB_W,
    parameter int P_OFF_W   = OFF_W,
    parameter int P_MAX_VL  = MAX_VL,
    parameter int P_MAX_SUB = MAX_SUB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [P_VL_W-1:0]  vec_len,
    input  logic               split_mode,
    input  logic [P_SUB_W-1:0] src_sub,
    input  logic [P_SUB_W-1:0] dst_sub,
    input  logic               cancel,
    input  logic               irq_req,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [P_OFF_W-1:0] src_off,
    output logic [P_OFF_W-1:0] dst_off,
    output logic               busy,
    output logic               done,
    output logic               len_err,
    output logic               irq_ack
);
    localparam int LC_W  = P_OFF_W + 1;
    localparam int SIDES = 2;

    typedef struct packed {
        seq_state_e         st;
        logic [LC_W-1:0]    cnt;
        logic [LC_W-1:0]    tot;
        logic [P_SUB_W-1:0] ssub;
        logic [P_SUB_W-1:0] dsub;
        logic               strided;
        logic               err;
    } ctl_t;

    ctl_t               q, d;
    logic [P_SUB_W-1:0] src_eff;
    logic [LC_W-1:0]    plan_total;
    logic               plan_bad;
    logic               accept;
    logic               load;
    logic [P_OFF_W-1:0] offs [SIDES];

    pkidx_plan #(
        .P_VL_W   (P_VL_W),
        .P_SUB_W  (P_SUB_W),
        .P_CNT_W  (LC_W),
        .P_MAX_VL (P_MAX_VL),
        .P_MAX_SUB(P_MAX_SUB)
    ) plan_i (
        .vl     (vec_len),
        .s_sub  (src_sub),
        .d_sub  (dst_sub),
        .split  (split_mode),
        .src_eff(src_eff),
        .total  (plan_total),
        .bad    (plan_bad)
    );

    assign accept = (q.st == ST_RUN) && out_ready && !cancel;
    assign load   = (q.st == ST_IDLE) && start;

    always_comb begin
        d     = q;
        d.err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.tot     = plan_total;
                    d.cnt     = plan_total;
                    d.ssub    = src_eff;
                    d.dsub    = dst_sub;
                    d.strided = split_mode;
                    if (plan_bad || vec_len == '0) begin
                        d.st  = ST_FIN;
                        d.err = plan_bad;
                    end else begin
                        d.st  = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (cancel) begin
                    d.st = ST_IDLE;
                end else if (accept) begin
                    d.cnt = q.cnt - LC_W'(1);
                    if (q.cnt == LC_W'(1)) d.st = ST_FIN;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q    <= d;
        end
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        pkidx_walker #(
            .P_OFF_W(P_OFF_W),
            .P_SUB_W(P_SUB_W),
            .P_CNT_W(LC_W)
        ) walk_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .step   (accept),
            .strided(q.strided),
            .sub    ((g == 0) ? q.ssub : q.dsub),
            .total  (q.tot),
            .off    (offs[g])
        );
    end

    assign src_off   = offs[0];
    assign dst_off   = offs[1];
    assign out_valid = (q.st == ST_RUN);
    assign busy      = (q.st == ST_RUN);
    assign done      = (q.st == ST_FIN);
    assign len_err   = q.err;
    assign irq_ack   = irq_req && (q.st != ST_RUN);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !cancel) |=>
            (out_valid && $stable(src_off) && $stable(dst_off)));

    // R3
    last_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && q.cnt == LC_W'(1)) |=> (done && !out_valid));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && vec_len == '0) |=> (done && !out_valid && !len_err));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_ack);

    // R9
    cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cancel) |=> (!busy && !done));
endmodule

// File: tb/pkidx_seq_tb_top.sv
module pkidx_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] vec_len = '0;
    logic       split_mode = 1'b0;
    logic [2:0] src_sub = 3'd1;
    logic [2:0] dst_sub = 3'd1;
    logic       cancel = 1'b0;
    logic       irq_req = 1'b0;
    logic       out_ready = 1'b0;
    logic       out_valid;
    logic [7:0] src_off;
    logic [7:0] dst_off;
    logic       busy;
    logic       done;
    logic       len_err;
    logic       irq_ack;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pkidx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .split_mode(split_mode), .src_sub(src_sub), .dst_sub(dst_sub),
        .cancel(cancel), .irq_req(irq_req), .out_ready(out_ready),
        .out_valid(out_valid), .src_off(src_off), .dst_off(dst_off),
        .busy(busy), .done(done), .len_err(len_err), .irq_ack(irq_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_off(input int t, input int s, input bit strided, input int n);
        int rows;
        if (!strided) return n;
        rows = t / s;
        return (n % rows) * s + n / rows;
    endfunction

    task automatic run_case(input int vl, input int s, input int d, input bit split,
                            input int stall_mod, input bit irq_on, input bit poke_start);
        int se, m, t, n, cyc, p_src, p_dst;
        bit have_prev;
        string rq;
        se = split ? s : d;
        m  = (se > d) ? se : d;
        t  = vl * m;
        rq = split ? "R2" : "R1";
        @(negedge clk);
        vec_len = 7'(vl); src_sub = 3'(s); dst_sub = 3'(d); split_mode = split;
        start = 1'b1; irq_req = irq_on;
        @(negedge clk);
        start = 1'b0;
        n = 0; cyc = 0; have_prev = 0; p_src = 0; p_dst = 0;
        while (n < t && cyc < 4000) begin
            out_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
            if (poke_start && cyc == 2) begin
                start = 1'b1; vec_len = 7'd3; dst_sub = 3'd1;
            end else begin
                start = 1'b0;
            end
            #1;
            chk(busy && out_valid, "R4 busy/valid during run", {busy, out_valid}, 3);
            if (irq_on) chk(!irq_ack, "R8 ack held while busy", irq_ack, 0);
            if (have_prev) begin
                chk(src_off == p_src, "R3 src stable on stall", src_off, p_src);
                chk(dst_off == p_dst, "R3 dst stable on stall", dst_off, p_dst);
            end
            if (out_ready) begin
                chk(src_off == exp_off(t, se, split, n), {rq, " src offset"}, src_off, exp_off(t, se, split, n));
                chk(dst_off == exp_off(t, d, split, n), {rq, " dst offset"}, dst_off, exp_off(t, d, split, n));
                n++;
                have_prev = 0;
            end else begin
                have_prev = 1; p_src = src_off; p_dst = dst_off;
            end
            cyc++;
            @(negedge clk);
        end
        chk(n == t, "R3 pair count", n, t);
        out_ready = 1'b0; start = 1'b0;
        #1;
        chk(done && !busy && !out_valid, "R5 done after last pair", {done, busy, out_valid}, 4);
        chk(!len_err, "R5 no error on good run", len_err, 0);
        if (irq_on) chk(irq_ack, "R8 ack once idle", irq_ack, 1);
        @(negedge clk);
        #1;
        chk(!done && !busy, "R5 done one cycle", {done, busy}, 0);
        irq_req = 1'b0;
    endtask

    task automatic run_reject(input int vl, input int s, input int d, input bit split,
                              input bit exp_err, input string req);
        @(negedge clk);
        vec_len = 7'(vl); src_sub = 3'(s); dst_sub = 3'(d); split_mode = split;
        start = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done && !out_valid && !busy, {req, " done without pairs"}, {done, out_valid, busy}, 4);
        chk(len_err == exp_err, {req, " error flag"}, len_err, exp_err);
        @(negedge clk);
        #1;
        chk(!done && !out_valid && !len_err, {req, " back to idle"}, {done, out_valid, len_err}, 0);
        out_ready = 1'b0;
    endtask

    task automatic run_cancel();
        @(negedge clk);
        vec_len = 7'd8; dst_sub = 3'd2; split_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; out_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(src_off == k, "R1 pair before cancel", src_off, k);
            @(negedge clk);
        end
        cancel = 1'b1;
        @(negedge clk);
        cancel = 1'b0;
        #1;
        chk(!busy && !out_valid && !done, "R9 idle after cancel", {busy, out_valid, done}, 0);
        @(negedge clk);
        #1;
        chk(!done && !out_valid, "R9 no done later", {done, out_valid}, 0);
        out_ready = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !busy && !done && !len_err, "R10 reset state",
            {out_valid, busy, done, len_err}, 0);
        rst_n = 1'b1;
        run_case(5, 1, 3, 1'b0, 0, 1'b0, 1'b0);   // R1 shared linear
        run_case(1, 1, 1, 1'b0, 0, 1'b0, 1'b0);   // R1 single pair
        run_case(64, 1, 4, 1'b0, 3, 1'b0, 1'b0);  // R1/R3 largest, stalls
        run_case(4, 0, 2, 1'b0, 0, 1'b0, 1'b0);   // R1 src_sub ignored
        run_case(6, 1, 4, 1'b1, 0, 1'b0, 1'b0);   // R2 pack
        run_case(4, 3, 1, 1'b1, 2, 1'b1, 1'b0);   // R2 unpack, R8 irq pending
        run_case(4, 2, 3, 1'b1, 0, 1'b0, 1'b1);   // R2 both >1, R4 start while busy
        run_case(3, 4, 3, 1'b1, 4, 1'b0, 1'b0);   // R2 both >1
        run_reject(0, 1, 2, 1'b0, 1'b0, "R6");
        run_reject(5, 2, 3, 1'b1, 1'b1, "R7 mismatch");
        run_reject(4, 1, 0, 1'b0, 1'b1, "R7 zero length");
        run_reject(65, 1, 1, 1'b0, 1'b1, "R7 vl too big");
        run_reject(2, 5, 1, 1'b1, 1'b1, "R7 src length range");
        run_cancel();
        irq_req = 1'b1;
        @(negedge clk);
        #1;
        chk(irq_ack, "R8 ack when idle", irq_ack, 1);
        irq_req = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule